// File: doc/BRIEF.md
# VirtIO Memory-Mapped Transport Register Block

This block is the device-side control register file of a VirtIO transport that is reached through memory-mapped registers. A driver talks to it over a plain 32-bit register bus: address, write enable, write data with byte strobes, read enable, and registered read data. The block returns identification words and a status byte. It serves the device feature words one page at a time and collects the driver's chosen features the same way. It holds the setup of every virtqueue behind a queue selector, and turns doorbell writes into per-queue pulses. It latches interrupt causes until the driver acknowledges them, and it keeps a small device-specific configuration space together with a generation count.

The device logic around the block reads the programmed ring addresses, queue sizes, ready flags, accepted features and configuration bytes from its output ports. It raises interrupt causes with single-cycle input pulses and updates configuration bytes through a byte-wide side port. Each update on that side port advances the generation count, so the driver can detect a torn read. Writing zero to the status register returns all driver-programmed transport state to its reset values.

Top module: `vmmio_regs`

## Requirements
- R1: Offset 0x000 reads 0x74726976, 0x004 the version, 0x008 the device ID and 0x00C the vendor ID. Writes to these offsets change nothing.
- R2: The status register at 0x070 stores the low 8 bits of a write and reads them back unchanged. The bits are acknowledge bit 0, driver bit 1, driver-ok bit 2, features-ok bit 3 and failed bit 7.
- R3: A page index written at 0x014 selects the 32-bit page of the device feature input that is read at 0x010. An index at or beyond the page count reads 0.
- R4: A page index written at 0x024 selects which 32-bit page of the driver feature output a write at 0x020 replaces. An out-of-range index makes the write have no effect.
- R5: A queue index written at 0x030 selects the queue. For a valid index, 0x034 reads the maximum size (256). For an index at or beyond the queue count, every queue register reads 0.
- R6: Queue size (0x038) and ring addresses (descriptor 0x080/0x084, available 0x090/0x094, used 0x0A0/0x0A4, low half first) are stored for the selected queue. They read back and appear on the queue output ports.
- R7: Writing bit 0 of 0x044 sets or clears the selected queue's ready flag, and 0x044 reads it back. While the flag is set, size and address writes are ignored. A size above the maximum is always ignored.
- R8: A write at 0x050 with value i produces a pulse on notify bit i for exactly the one cycle after the write. An index at or beyond the queue count produces no pulse.
- R9: Interrupt status at 0x060 has bit 0 for used-buffer events and bit 1 for configuration-change events, each set by its input pulse. Writing a mask at 0x064 clears exactly the masked bits, and a pulse in the same cycle wins. The irq output is the OR of the status bits.
- R10: Writing 0 to the status register clears all ready flags, queue sizes, ring addresses, driver feature words and interrupt status.
- R11: Configuration space starts at 0x100. A write stores only the bytes whose strobe bit is set, so byte, halfword and word accesses all work. A read returns the whole word, and the bytes appear on the configuration output.
- R12: A device-side configuration byte write stores the byte and increments the generation count read at 0x0FC.
- R13: Read data is registered. It reflects the register state in the cycle rd_en is high, appears after that clock edge, and holds while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte strobes (used in configuration space) |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| dev_features | input | FEAT_PAGES*32 | Device feature words, page 0 lowest |
| drv_features | output | FEAT_PAGES*32 | Driver-accepted feature words |
| dev_status | output | 8 | Current status byte |
| q_ready | output | NUM_Q | Per-queue ready flags |
| q_size | output | NUM_Q*SZ_W | Per-queue sizes |
| q_desc | output | NUM_Q*64 | Descriptor table addresses |
| q_avail | output | NUM_Q*64 | Available ring addresses |
| q_used | output | NUM_Q*64 | Used ring addresses |
| q_notify | output | NUM_Q | One-cycle doorbell pulses |
| evt_used | input | 1 | Used-buffer interrupt cause pulse |
| evt_cfg | input | 1 | Configuration-change interrupt cause pulse |
| irq | output | 1 | Level interrupt |
| dev_cfg_we | input | 1 | Device-side configuration byte write |
| dev_cfg_addr | input | log2(CFG_BYTES) | Device-side byte offset |
| dev_cfg_wdata | input | 8 | Device-side byte |
| cfg_bytes | output | CFG_BYTES*8 | Configuration space contents, byte 0 lowest |

## Verification
Every register update, notify pulse and interrupt status change takes effect at the clock edge that samples the write or the event pulse. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, half a cycle after the update. Read data is due one edge after rd_en, so the bench raises rd_en on a falling edge and reads bus_rdata on the following one. The bench also checks that bus_rdata has not yet changed before that edge, and that it holds afterwards. The notify pulse is checked high on the first falling edge after the write and low on the next.

// File: rtl/vmmio_pkg.sv
// Package: register offsets and queue field codes shared by the transport
// register block. Offsets are byte addresses on the driver bus.
package vmmio_pkg;
    localparam logic [31:0] MAGIC_WORD = 32'h7472_6976;

    localparam int unsigned OFF_MAGIC     = 'h000;
    localparam int unsigned OFF_VERSION   = 'h004;
    localparam int unsigned OFF_DEVID     = 'h008;
    localparam int unsigned OFF_VENDOR    = 'h00C;
    localparam int unsigned OFF_DFEAT     = 'h010;
    localparam int unsigned OFF_DFEAT_SEL = 'h014;
    localparam int unsigned OFF_AFEAT     = 'h020;
    localparam int unsigned OFF_AFEAT_SEL = 'h024;
    localparam int unsigned OFF_QSEL      = 'h030;
    localparam int unsigned OFF_QMAX      = 'h034;
    localparam int unsigned OFF_QSIZE     = 'h038;
    localparam int unsigned OFF_QREADY    = 'h044;
    localparam int unsigned OFF_DOORBELL  = 'h050;
    localparam int unsigned OFF_ISR       = 'h060;
    localparam int unsigned OFF_ISR_ACK   = 'h064;
    localparam int unsigned OFF_STATUS    = 'h070;
    localparam int unsigned OFF_DESC_LO   = 'h080;
    localparam int unsigned OFF_DESC_HI   = 'h084;
    localparam int unsigned OFF_AVAIL_LO  = 'h090;
    localparam int unsigned OFF_AVAIL_HI  = 'h094;
    localparam int unsigned OFF_USED_LO   = 'h0A0;
    localparam int unsigned OFF_USED_HI   = 'h0A4;
    localparam int unsigned OFF_GEN       = 'h0FC;
    localparam int unsigned OFF_CFG       = 'h100;

    typedef enum logic [3:0] {
        QF_NONE, QF_SIZE, QF_READY,
        QF_DESC_LO, QF_DESC_HI, QF_AVAIL_LO, QF_AVAIL_HI, QF_USED_LO, QF_USED_HI
    } qfield_e;
endpackage

// File: rtl/vmmio_queue.sv
// Module: one virtqueue's programmable state (size, ready flag, three ring
// addresses). Assumes the top decodes the field and only asserts wr when
// this queue is the selected one. clr is the transport reset from status 0.
module vmmio_queue
    import vmmio_pkg::*;
#(
    parameter int Q_MAX = 256,
    parameter int SZ_W  = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr,
    input  qfield_e         fld,
    input  logic [31:0]     wdata,
    output logic            ready,
    output logic [SZ_W-1:0] size,
    output logic [63:0]     desc,
    output logic [63:0]     avail,
    output logic [63:0]     used
);
    logic cfg_ok;
    assign cfg_ok = wr && !ready;

    // Update the queue fields; setup fields are frozen while ready.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ready <= 1'b0;
            size  <= '0;
            desc  <= '0;
            avail <= '0;
            used  <= '0;
        end else begin
            if (wr && fld == QF_READY) ready <= wdata[0];
            if (cfg_ok) begin
                case (fld)
                    QF_SIZE:     if (wdata <= 32'(Q_MAX)) size <= wdata[SZ_W-1:0];
                    QF_DESC_LO:  desc[31:0]   <= wdata;
                    QF_DESC_HI:  desc[63:32]  <= wdata;
                    QF_AVAIL_LO: avail[31:0]  <= wdata;
                    QF_AVAIL_HI: avail[63:32] <= wdata;
                    QF_USED_LO:  used[31:0]   <= wdata;
                    QF_USED_HI:  used[63:32]  <= wdata;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/vmmio_irq.sv
// Module: interrupt cause latch. Causes are set by one-cycle pulses and
// cleared by a mask write; a pulse in the same cycle as its clear wins.
// Assumes clr (transport reset) has priority over everything.
module vmmio_irq #(
    parameter int N_CAUSE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [N_CAUSE-1:0] set,
    input  logic               ack_we,
    input  logic [N_CAUSE-1:0] ack_mask,
    output logic [N_CAUSE-1:0] isr,
    output logic               irq
);
    // Latch causes, drop acknowledged bits, keep new pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) isr <= '0;
        else               isr <= (isr & ~(ack_we ? ack_mask : '0)) | set;
    end

    // Level interrupt while any cause is pending.
    assign irq = |isr;
endmodule

// File: rtl/vmmio_cfg.sv
// Module: device-specific configuration bytes with a generation count.
// Driver writes go through byte strobes on a word index; the device side
// writes single bytes and wins on a collision. Only device writes advance
// the generation count.
module vmmio_cfg #(
    parameter int CFG_BYTES = 16,
    parameter int GEN_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         drv_we,
    input  logic [$clog2(CFG_BYTES)-3:0] word_idx,
    input  logic [3:0]                   wstrb,
    input  logic [31:0]                  wdata,
    input  logic                         dev_we,
    input  logic [$clog2(CFG_BYTES)-1:0] dev_addr,
    input  logic [7:0]                   dev_wdata,
    output logic [31:0]                  rd_word,
    output logic [CFG_BYTES*8-1:0]       bytes_o,
    output logic [GEN_W-1:0]             gen_q
);
    logic [7:0] mem [CFG_BYTES];

    // Store strobed driver bytes, then the device byte on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CFG_BYTES; i++) mem[i] <= '0;
        end else begin
            if (drv_we)
                for (int b = 0; b < 4; b++)
                    if (wstrb[b]) mem[{word_idx, 2'(b)}] <= wdata[8*b +: 8];
            if (dev_we) mem[dev_addr] <= dev_wdata;
        end
    end

    // Count device-side configuration changes.
    always_ff @(posedge clk) begin
        if (!rst_n)      gen_q <= '0;
        else if (dev_we) gen_q <= gen_q + 1'b1;
    end

    // Assemble the addressed word for the read path.
    always_comb begin
        for (int b = 0; b < 4; b++) rd_word[8*b +: 8] = mem[{word_idx, 2'(b)}];
    end

    for (genvar g = 0; g < CFG_BYTES; g++) begin : g_out
        assign bytes_o[8*g +: 8] = mem[g];
    end
endmodule

// File: rtl/vmmio_regs.sv
// Module: top of the transport register block. Decodes the driver bus,
// holds identification, status, feature banks and selectors, and hands
// queue, interrupt and configuration state to the sub-blocks. Assumes
// registers below the configuration space are accessed as aligned words.
module vmmio_regs
    import vmmio_pkg::*;
#(
    parameter int          ADDR_W     = 9,
    parameter int          NUM_Q      = 2,
    parameter int          Q_MAX      = 256,
    parameter int          FEAT_PAGES = 2,
    parameter int          CFG_BYTES  = 16,
    parameter int          GEN_W      = 8,
    parameter logic [31:0] VERSION    = 32'd2,
    parameter logic [31:0] DEVICE_ID  = 32'd1,
    parameter logic [31:0] VENDOR_ID  = 32'h0000_5A5A
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    bus_addr,
    input  logic                                 bus_we,
    input  logic [31:0]                          bus_wdata,
    input  logic [3:0]                           bus_wstrb,
    input  logic                                 bus_re,
    output logic [31:0]                          bus_rdata,
    input  logic [FEAT_PAGES*32-1:0]             dev_features,
    output logic [FEAT_PAGES*32-1:0]             drv_features,
    output logic [7:0]                           dev_status,
    output logic [NUM_Q-1:0]                     q_ready,
    output logic [NUM_Q*$clog2(Q_MAX+1)-1:0]     q_size,
    output logic [NUM_Q*64-1:0]                  q_desc,
    output logic [NUM_Q*64-1:0]                  q_avail,
    output logic [NUM_Q*64-1:0]                  q_used,
    output logic [NUM_Q-1:0]                     q_notify,
    input  logic                                 evt_used,
    input  logic                                 evt_cfg,
    output logic                                 irq,
    input  logic                                 dev_cfg_we,
    input  logic [$clog2(CFG_BYTES)-1:0]         dev_cfg_addr,
    input  logic [7:0]                           dev_cfg_wdata,
    output logic [CFG_BYTES*8-1:0]               cfg_bytes
);
    localparam int SZ_W = $clog2(Q_MAX + 1);
    localparam int QI_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
    localparam int FP_W = (FEAT_PAGES > 1) ? $clog2(FEAT_PAGES) : 1;
    localparam int BA_W = $clog2(CFG_BYTES);

    logic [31:0]       dfsel_q, afsel_q, qsel_q;
    logic [7:0]        status_q;
    logic              dev_rst;
    logic [1:0]        isr;
    logic [31:0]       cfg_rd;
    logic [GEN_W-1:0]  gen_q;
    logic [ADDR_W-1:0] cfg_off;
    logic              in_cfg, q_ok;
    logic [QI_W-1:0]   q_idx;
    qfield_e           qf;
    logic [31:0]       rd_mux;

    assign cfg_off  = bus_addr - ADDR_W'(OFF_CFG);
    assign in_cfg   = (bus_addr >= ADDR_W'(OFF_CFG)) && (cfg_off < ADDR_W'(CFG_BYTES));
    assign q_ok     = qsel_q < 32'(NUM_Q);
    assign q_idx    = qsel_q[QI_W-1:0];
    assign dev_rst  = bus_we && bus_addr == ADDR_W'(OFF_STATUS) && bus_wdata[7:0] == 8'h00;
    assign dev_status = status_q;

    // Map the bus address onto a per-queue field code.
    always_comb begin
        qf = QF_NONE;
        case (bus_addr)
            ADDR_W'(OFF_QSIZE):    qf = QF_SIZE;
            ADDR_W'(OFF_QREADY):   qf = QF_READY;
            ADDR_W'(OFF_DESC_LO):  qf = QF_DESC_LO;
            ADDR_W'(OFF_DESC_HI):  qf = QF_DESC_HI;
            ADDR_W'(OFF_AVAIL_LO): qf = QF_AVAIL_LO;
            ADDR_W'(OFF_AVAIL_HI): qf = QF_AVAIL_HI;
            ADDR_W'(OFF_USED_LO):  qf = QF_USED_LO;
            ADDR_W'(OFF_USED_HI):  qf = QF_USED_HI;
            default:               qf = QF_NONE;
        endcase
    end

    // Selectors and status byte, written as whole words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dfsel_q  <= '0;
            afsel_q  <= '0;
            qsel_q   <= '0;
            status_q <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                ADDR_W'(OFF_DFEAT_SEL): dfsel_q  <= bus_wdata;
                ADDR_W'(OFF_AFEAT_SEL): afsel_q  <= bus_wdata;
                ADDR_W'(OFF_QSEL):      qsel_q   <= bus_wdata;
                ADDR_W'(OFF_STATUS):    status_q <= bus_wdata[7:0];
                default: ;
            endcase
        end
    end

    // Driver-accepted feature pages, cleared by the transport reset.
    always_ff @(posedge clk) begin
        if (!rst_n || dev_rst)
            drv_features <= '0;
        else if (bus_we && bus_addr == ADDR_W'(OFF_AFEAT) && afsel_q < 32'(FEAT_PAGES))
            drv_features[32*int'(afsel_q[FP_W-1:0]) +: 32] <= bus_wdata;
    end

    // Doorbell: one-cycle pulse on the queue named by the written value.
    always_ff @(posedge clk) begin
        if (!rst_n) q_notify <= '0;
        else
            for (int i = 0; i < NUM_Q; i++)
                q_notify[i] <= bus_we && bus_addr == ADDR_W'(OFF_DOORBELL) && bus_wdata == 32'(i);
    end

    for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
        vmmio_queue #(.Q_MAX(Q_MAX), .SZ_W(SZ_W)) u_queue (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (dev_rst),
            .wr    (bus_we && qsel_q == 32'(g)),
            .fld   (qf),
            .wdata (bus_wdata),
            .ready (q_ready[g]),
            .size  (q_size[g*SZ_W +: SZ_W]),
            .desc  (q_desc[g*64 +: 64]),
            .avail (q_avail[g*64 +: 64]),
            .used  (q_used[g*64 +: 64])
        );
    end

    vmmio_irq #(.N_CAUSE(2)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (dev_rst),
        .set      ({evt_cfg, evt_used}),
        .ack_we   (bus_we && bus_addr == ADDR_W'(OFF_ISR_ACK)),
        .ack_mask (bus_wdata[1:0]),
        .isr      (isr),
        .irq      (irq)
    );

    vmmio_cfg #(.CFG_BYTES(CFG_BYTES), .GEN_W(GEN_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .drv_we    (bus_we && in_cfg),
        .word_idx  (cfg_off[BA_W-1:2]),
        .wstrb     (bus_wstrb),
        .wdata     (bus_wdata),
        .dev_we    (dev_cfg_we),
        .dev_addr  (dev_cfg_addr),
        .dev_wdata (dev_cfg_wdata),
        .rd_word   (cfg_rd),
        .bytes_o   (cfg_bytes),
        .gen_q     (gen_q)
    );

    // Select the read value for the addressed register.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(OFF_MAGIC):    rd_mux = MAGIC_WORD;
            ADDR_W'(OFF_VERSION):  rd_mux = VERSION;
            ADDR_W'(OFF_DEVID):    rd_mux = DEVICE_ID;
            ADDR_W'(OFF_VENDOR):   rd_mux = VENDOR_ID;
            ADDR_W'(OFF_DFEAT):    if (dfsel_q < 32'(FEAT_PAGES))
                                       rd_mux = dev_features[32*int'(dfsel_q[FP_W-1:0]) +: 32];
            ADDR_W'(OFF_QMAX):     if (q_ok) rd_mux = 32'(Q_MAX);
            ADDR_W'(OFF_QSIZE):    if (q_ok) rd_mux = 32'(q_size[int'(q_idx)*SZ_W +: SZ_W]);
            ADDR_W'(OFF_QREADY):   if (q_ok) rd_mux = {31'd0, q_ready[q_idx]};
            ADDR_W'(OFF_DESC_LO):  if (q_ok) rd_mux = q_desc[int'(q_idx)*64 +: 32];
            ADDR_W'(OFF_DESC_HI):  if (q_ok) rd_mux = q_desc[int'(q_idx)*64+32 +: 32];
            ADDR_W'(OFF_AVAIL_LO): if (q_ok) rd_mux = q_avail[int'(q_idx)*64 +: 32];
            ADDR_W'(OFF_AVAIL_HI): if (q_ok) rd_mux = q_avail[int'(q_idx)*64+32 +: 32];
            ADDR_W'(OFF_USED_LO):  if (q_ok) rd_mux = q_used[int'(q_idx)*64 +: 32];
            ADDR_W'(OFF_USED_HI):  if (q_ok) rd_mux = q_used[int'(q_idx)*64+32 +: 32];
            ADDR_W'(OFF_ISR):      rd_mux = {30'd0, isr};
            ADDR_W'(OFF_STATUS):   rd_mux = {24'd0, status_q};
            ADDR_W'(OFF_GEN):      rd_mux = 32'(gen_q);
            default:               if (in_cfg) rd_mux = cfg_rd;
        endcase
    end

    // Register the read value; hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/vmmio_regs_chk.sv
// Module: property checker for the transport register block, attached to
// every instance of the top through the bind statement at the end.
module vmmio_regs_chk #(
    parameter int NUM_Q      = 2,
    parameter int SZ_W       = 9,
    parameter int FEAT_PAGES = 2,
    parameter int GEN_W      = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_re,
    input logic [31:0]              bus_rdata,
    input logic [NUM_Q-1:0]         q_notify,
    input logic [NUM_Q-1:0]         q_ready,
    input logic [SZ_W-1:0]          q0_size,
    input logic                     evt_used,
    input logic                     irq,
    input logic                     dev_rst,
    input logic [FEAT_PAGES*32-1:0] drv_features,
    input logic                     dev_cfg_we,
    input logic [GEN_W-1:0]         gen
);
    // R8
    notify_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_notify));

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_used && !dev_rst) |=> irq);

    // R10
    transport_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> (q_ready == '0 && drv_features == '0 && !irq));

    // R7
    ready_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_ready[0] && !dev_rst) |=> $stable(q0_size));

    // R12
    gen_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_cfg_we |=> gen == $past(gen) + 1'b1);

    // R13
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));
endmodule

bind vmmio_regs vmmio_regs_chk #(
    .NUM_Q(NUM_Q), .SZ_W(SZ_W), .FEAT_PAGES(FEAT_PAGES), .GEN_W(GEN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_re       (bus_re),
    .bus_rdata    (bus_rdata),
    .q_notify     (q_notify),
    .q_ready      (q_ready),
    .q0_size      (q_size[SZ_W-1:0]),
    .evt_used     (evt_used),
    .irq          (irq),
    .dev_rst      (dev_rst),
    .drv_features (drv_features),
    .dev_cfg_we   (dev_cfg_we),
    .gen          (u_cfg.gen_q)
);

// File: tb/test_vmmio_regs.sv
// Bench: walks a table of bus transactions with expected read values, then
// runs directed tests on outputs, doorbell, interrupts, generation count,
// read timing and the transport reset.
module test_vmmio_regs;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [8:0]  addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 44;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 9'h000, 32'h0, 4'hF, 32'h7472_6976, 8'd1},  // R1 magic
        '{1'b0, 9'h004, 32'h0, 4'hF, 32'd2,         8'd1},  // R1 version
        '{1'b0, 9'h008, 32'h0, 4'hF, 32'd1,         8'd1},  // R1 device id
        '{1'b0, 9'h00C, 32'h0, 4'hF, 32'h5A5A,      8'd1},  // R1 vendor id
        '{1'b1, 9'h000, 32'h0, 4'hF, 32'h0,         8'd1},
        '{1'b0, 9'h000, 32'h0, 4'hF, 32'h7472_6976, 8'd1},  // R1 write ignored
        '{1'b1, 9'h070, 32'h0B, 4'hF, 32'h0,        8'd2},
        '{1'b0, 9'h070, 32'h0, 4'hF, 32'h0B,        8'd2},  // R2
        '{1'b1, 9'h070, 32'h8F, 4'hF, 32'h0,        8'd2},
        '{1'b0, 9'h070, 32'h0, 4'hF, 32'h8F,        8'd2},  // R2 failed bit
        '{1'b1, 9'h014, 32'd1, 4'hF, 32'h0,         8'd3},
        '{1'b0, 9'h010, 32'h0, 4'hF, 32'hFEED_0002, 8'd3},  // R3 page 1
        '{1'b1, 9'h014, 32'd7, 4'hF, 32'h0,         8'd3},
        '{1'b0, 9'h010, 32'h0, 4'hF, 32'h0,         8'd3},  // R3 out of range
        '{1'b1, 9'h030, 32'd0, 4'hF, 32'h0,         8'd5},
        '{1'b0, 9'h034, 32'h0, 4'hF, 32'd256,       8'd5},  // R5 max
        '{1'b1, 9'h030, 32'd5, 4'hF, 32'h0,         8'd5},
        '{1'b0, 9'h034, 32'h0, 4'hF, 32'd0,         8'd5},  // R5 bad select
        '{1'b0, 9'h038, 32'h0, 4'hF, 32'd0,         8'd5},
        '{1'b1, 9'h030, 32'd1, 4'hF, 32'h0,         8'd6},
        '{1'b1, 9'h038, 32'd128, 4'hF, 32'h0,       8'd6},
        '{1'b0, 9'h038, 32'h0, 4'hF, 32'd128,       8'd6},  // R6 size
        '{1'b1, 9'h080, 32'h1000, 4'hF, 32'h0,      8'd6},
        '{1'b1, 9'h084, 32'hABCD, 4'hF, 32'h0,      8'd6},
        '{1'b0, 9'h080, 32'h0, 4'hF, 32'h1000,      8'd6},  // R6 desc low
        '{1'b0, 9'h084, 32'h0, 4'hF, 32'hABCD,      8'd6},  // R6 desc high
        '{1'b1, 9'h044, 32'd1, 4'hF, 32'h0,         8'd7},
        '{1'b0, 9'h044, 32'h0, 4'hF, 32'd1,         8'd7},  // R7 ready
        '{1'b1, 9'h038, 32'd64, 4'hF, 32'h0,        8'd7},
        '{1'b0, 9'h038, 32'h0, 4'hF, 32'd128,       8'd7},  // R7 size frozen
        '{1'b1, 9'h080, 32'h2222, 4'hF, 32'h0,      8'd7},
        '{1'b0, 9'h080, 32'h0, 4'hF, 32'h1000,      8'd7},  // R7 addr frozen
        '{1'b1, 9'h030, 32'd0, 4'hF, 32'h0,         8'd7},
        '{1'b1, 9'h038, 32'd300, 4'hF, 32'h0,       8'd7},
        '{1'b0, 9'h038, 32'h0, 4'hF, 32'd0,         8'd7},  // R7 above max
        '{1'b1, 9'h038, 32'd256, 4'hF, 32'h0,       8'd7},
        '{1'b0, 9'h038, 32'h0, 4'hF, 32'd256,       8'd7},  // R7 at max
        '{1'b1, 9'h100, 32'h1122_3344, 4'hF, 32'h0, 8'd11},
        '{1'b0, 9'h100, 32'h0, 4'hF, 32'h1122_3344, 8'd11}, // R11 word
        '{1'b1, 9'h102, 32'h00AA_0000, 4'h4, 32'h0, 8'd11},
        '{1'b0, 9'h100, 32'h0, 4'hF, 32'h11AA_3344, 8'd11}, // R11 byte
        '{1'b1, 9'h104, 32'hBEEF_0000, 4'hC, 32'h0, 8'd11},
        '{1'b0, 9'h104, 32'h0, 4'hF, 32'hBEEF_0000, 8'd11}, // R11 halfword
        '{1'b0, 9'h0FC, 32'h0, 4'hF, 32'd0,         8'd12}  // R12 initial
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [8:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [3:0]   bus_wstrb = 4'hF;
    logic         bus_re = 1'b0;
    logic [31:0]  bus_rdata;
    logic [63:0]  dev_features = {32'hFEED_0002, 32'h0000_0001};
    logic [63:0]  drv_features;
    logic [7:0]   dev_status;
    logic [1:0]   q_ready;
    logic [17:0]  q_size;
    logic [127:0] q_desc, q_avail, q_used;
    logic [1:0]   q_notify;
    logic         evt_used = 1'b0, evt_cfg = 1'b0;
    logic         irq;
    logic         dev_cfg_we = 1'b0;
    logic [3:0]   dev_cfg_addr = '0;
    logic [7:0]   dev_cfg_wdata = '0;
    logic [127:0] cfg_bytes;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmmio_regs i_vmmio_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .dev_features(dev_features),
        .drv_features(drv_features), .dev_status(dev_status),
        .q_ready(q_ready), .q_size(q_size), .q_desc(q_desc),
        .q_avail(q_avail), .q_used(q_used), .q_notify(q_notify),
        .evt_used(evt_used), .evt_cfg(evt_cfg), .irq(irq),
        .dev_cfg_we(dev_cfg_we), .dev_cfg_addr(dev_cfg_addr),
        .dev_cfg_wdata(dev_cfg_wdata), .cfg_bytes(cfg_bytes)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Write one word; returns on the falling edge after the write edge.
    task automatic bus_write(input logic [8:0] a, input logic [31:0] d, input logic [3:0] s);
        bus_addr = a; bus_wdata = d; bus_wstrb = s; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0; bus_wstrb = 4'hF;
    endtask

    // Read one word; data sampled on the falling edge after the read edge.
    task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        check("R13 reset rdata", bus_rdata, 0);
        check("R9 reset irq", irq, 0);
        check("R7 reset ready", q_ready, 0);
        check("R8 reset notify", q_notify, 0);
        check("R4 reset drv features", drv_features, 0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data, VECS[i].strb);
            else begin
                bus_read(VECS[i].addr, rd);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
            end
        end

        // Queue outputs after the table: queue 1 ready, size 128, desc set.
        check("R6 q1 size port", q_size[17:9], 128);
        check("R6 q1 desc port", q_desc[127:64], 64'h0000_ABCD_0000_1000);
        check("R7 ready port", q_ready, 2'b10);
        check("R2 status port", dev_status, 8'h8F);

        // Driver features.
        bus_write(9'h024, 32'd1, 4'hF);
        bus_write(9'h020, 32'hCAFE_0001, 4'hF);
        check("R4 page 1 stored", drv_features, {32'hCAFE_0001, 32'h0});
        bus_write(9'h024, 32'd3, 4'hF);
        bus_write(9'h020, 32'h1234, 4'hF);
        check("R4 out of range ignored", drv_features, {32'hCAFE_0001, 32'h0});

        // Doorbell.
        bus_write(9'h050, 32'd1, 4'hF);
        check("R8 pulse on queue 1", q_notify, 2'b10);
        @(negedge clk);
        check("R8 pulse one cycle", q_notify, 2'b00);
        bus_write(9'h050, 32'd2, 4'hF);
        check("R8 out of range no pulse", q_notify, 2'b00);

        // Interrupt causes.
        evt_used = 1'b1; @(negedge clk); evt_used = 1'b0;
        check("R9 irq raised", irq, 1);
        evt_cfg = 1'b1; @(negedge clk); evt_cfg = 1'b0;
        bus_read(9'h060, rd);
        check("R9 both causes", rd, 3);
        bus_write(9'h064, 32'd1, 4'hF);
        bus_read(9'h060, rd);
        check("R9 ack clears masked only", rd, 2);
        check("R9 irq still high", irq, 1);
        evt_used = 1'b1;
        bus_write(9'h064, 32'd3, 4'hF);
        evt_used = 1'b0;
        bus_read(9'h060, rd);
        check("R9 set wins over ack", rd, 1);
        bus_write(9'h064, 32'd1, 4'hF);
        check("R9 irq low when clear", irq, 0);

        // Generation count and device-side write.
        dev_cfg_addr = 4'd3; dev_cfg_wdata = 8'h77; dev_cfg_we = 1'b1;
        @(negedge clk); dev_cfg_we = 1'b0;
        bus_read(9'h0FC, rd);
        check("R12 generation stepped", rd, 1);
        bus_read(9'h100, rd);
        check("R12 device byte stored", rd, 32'h77AA_3344);
        check("R11 config port", cfg_bytes[31:0], 32'h77AA_3344);

        // Read timing: no change before the edge, hold after.
        bus_addr = 9'h000; bus_re = 1'b1;
        #1;
        check("R13 not before edge", bus_rdata, 32'h77AA_3344);
        @(posedge clk); @(negedge clk); bus_re = 1'b0;
        check("R13 due after edge", bus_rdata, 32'h7472_6976);
        bus_addr = 9'h070;
        repeat (3) @(negedge clk);
        check("R13 hold while idle", bus_rdata, 32'h7472_6976);

        // Transport reset via status 0.
        evt_used = 1'b1; @(negedge clk); evt_used = 1'b0;
        bus_write(9'h070, 32'd0, 4'hF);
        check("R10 ready cleared", q_ready, 0);
        check("R10 sizes cleared", q_size, 0);
        check("R10 addresses cleared", q_desc, 0);
        check("R10 features cleared", drv_features, 0);
        check("R10 irq cleared", irq, 0);
        bus_read(9'h070, rd);
        check("R2 status zero", rd, 0);
        bus_read(9'h060, rd);
        check("R10 isr zero", rd, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule